// File: doc/BRIEF.md
# PWM Period and High-Time Meter

This block measures a pulse-width-modulated signal that arrives from outside the chip. It first brings the raw pin into the clock domain and then rejects any level change that does not hold for a programmable number of samples. The cleaned signal feeds two capture paths, and the two paths respond to edges of opposite direction. One of those edge directions is the trigger. The trigger takes a snapshot of a free-running count into the period path and reloads the counter in the same cycle. The other edge takes a snapshot into the width path. The period and the active-phase duration are therefore read directly, without any subtraction.

A polarity input chooses which edge is the trigger. With the rising edge chosen, the block reports the period and the high time. With the falling edge chosen, it reports the period and the low time. Each path keeps a capture flag and an overcapture flag, and each has its own clear strobe. A one-cycle strobe marks every new period that has a matching width behind it. If the counter runs out of range, the block saturates it and raises a timeout flag.

Top module: `pwm_in_meter`

## Requirements
- R1: The raw input passes through a two-stage synchroniser and then a glitch filter with FILT_LEN = 4. The filtered level changes only after four consecutive synchronised samples differ from it, so a pulse of three clocks or less causes no capture.
- R2: With pol_i = 0, the rising filtered edge is the trigger and the period path captures on it, while the width path captures on the falling edge (high time). With pol_i = 1 the two edge directions swap, and the width path holds the low time. The filtered rising and falling edge pulses never occur in the same cycle.
- R3: A trigger reloads the counter to 1. Otherwise the counter advances by one each clock. A period capture therefore equals the number of clocks between two trigger edges, and a width capture equals the number of clocks from the trigger edge to the opposite edge.
- R4: The first trigger after enable arms the block and captures nothing. Before the block is armed, neither path captures.
- R5: A capture sets that path's flag. A clear strobe that arrives without a capture clears both the flag and the overcapture flag of that path. When a capture and a clear fall in the same cycle, the flag ends up set and the overcapture flag ends up clear.
- R6: A capture that arrives while the path's flag is still set, with no clear in that cycle, sets the overcapture flag. The overcapture flag is set only while the capture flag is set.
- R7: valid_o pulses for one cycle, in the same cycle the new period value appears. It does so only if the width path captured since the previous trigger, and only if the counter was not saturated at that trigger.
- R8: The counter stops at its all-ones value (1023 when CNT_W = 10) and timeout_o rises while it stays there. The next trigger clears timeout_o, and its period capture holds the saturated value.
- R9: While en_i is low, the counter holds 0, the block disarms, neither path captures and timeout_o is low. The captured values and flags keep their contents.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for counting and sampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Unsynchronised PWM input |
| pol_i | input | 1 | 0: rising edge is trigger; 1: falling edge is trigger |
| en_i | input | 1 | Measurement enable |
| clr_per_i | input | 1 | Clears the period path's flag and overcapture flag |
| clr_wid_i | input | 1 | Clears the width path's flag and overcapture flag |
| per_val_o | output | CNT_W | Last captured period |
| per_flag_o | output | 1 | Period capture flag |
| per_ovr_o | output | 1 | Period overcapture flag |
| wid_val_o | output | CNT_W | Last captured active-phase width |
| wid_flag_o | output | 1 | Width capture flag |
| wid_ovr_o | output | 1 | Width overcapture flag |
| valid_o | output | 1 | One-cycle strobe marking a complete period/width pair |
| timeout_o | output | 1 | Counter saturated without a trigger |

## Verification
The assertions assume that pol_i changes only while en_i is low. They also assume that the clear strobes are the only way software affects the flags. The stimulus changes the polarity only inside a disabled window and re-enables before the next burst. The assertions also assume that raw_i may toggle freely, glitches included, because the filter stands between the pin and every capture. The bench therefore mixes clean bursts, a three-clock glitch and a long idle stretch that drives the counter into saturation.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;

    // Index of each capture path in the path arrays
    typedef enum logic {
        PATH_PER = 1'b0,
        PATH_WID = 1'b1
    } path_e;

    localparam int NUM_PATHS = 2;

    // Edge that drives a given path for a chosen polarity
    function automatic logic path_edge(input path_e path, input logic pol,
                                       input logic rise, input logic fall);
        logic trig_is_fall;
        trig_is_fall = pol;
        if (path == PATH_PER) begin
            return trig_is_fall ? fall : rise;
        end
        return trig_is_fall ? rise : fall;
    endfunction

endpackage

// File: rtl/pwm_in_filter.sv
module pwm_in_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   level;
        logic [RUN_W-1:0]       run;
        logic                   rise;
        logic                   fall;
    } filt_t;

    filt_t st_d, st_q;
    logic  sample;

    assign sample = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw_i};
        if (sample != st_q.level) begin
            if (st_q.run == RUN_LAST) begin
                st_d.level = sample;
                st_d.run   = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
        st_d.rise = st_d.level & ~st_q.level;
        st_d.fall = ~st_d.level & st_q.level;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

    // R2: the two edge pulses are mutually exclusive
    assert_edge_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));

    // R1: an edge pulse only follows a completed run of agreeing samples
    assert_edge_after_run_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run == RUN_LAST && sample != st_q.level) |=> (rise_o || fall_o));

endmodule

// File: rtl/pwm_cap_chan.sv
module pwm_cap_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cap_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] val_o,
    output logic             flag_o,
    output logic             ovr_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             flag;
        logic             ovr;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (cap_i) begin
            ch_d.val  = cnt_i;
            ch_d.flag = 1'b1;
            ch_d.ovr  = ~clr_i & (ch_q.ovr | ch_q.flag);
        end else if (clr_i) begin
            ch_d.flag = 1'b0;
            ch_d.ovr  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign val_o  = ch_q.val;
    assign flag_o = ch_q.flag;
    assign ovr_o  = ch_q.ovr;

    // R6: capture over an uncleared flag marks overcapture
    assert_ovr_on_recapture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_i && flag_o && !clr_i) |=> ovr_o);

    // R6: overcapture never stands alone
    assert_ovr_needs_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_o |-> flag_o);

    // R5: a lone clear empties both flags
    assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !cap_i) |=> (!flag_o && !ovr_o));

    // R5: capture wins over a simultaneous clear
    assert_cap_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_i && clr_i) |=> (flag_o && !ovr_o));

endmodule

// File: rtl/pwm_in_meter.sv
module pwm_in_meter
    import pwm_meas_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             raw_i,
    input  logic             pol_i,
    input  logic             en_i,
    input  logic             clr_per_i,
    input  logic             clr_wid_i,
    output logic [CNT_W-1:0] per_val_o,
    output logic             per_flag_o,
    output logic             per_ovr_o,
    output logic [CNT_W-1:0] wid_val_o,
    output logic             wid_flag_o,
    output logic             wid_ovr_o,
    output logic             valid_o,
    output logic             timeout_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             win;
        logic             tmo;
        logic             valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic rise_w, fall_w;
    logic [NUM_PATHS-1:0] edge_w, cap_w, clr_w, flag_w, ovr_w;
    logic [CNT_W-1:0]     val_w [NUM_PATHS];

    pwm_in_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) filt_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .raw_i (raw_i),
        .rise_o(rise_w),
        .fall_o(fall_w)
    );

    assign clr_w[int'(PATH_PER)] = clr_per_i;
    assign clr_w[int'(PATH_WID)] = clr_wid_i;

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        assign edge_w[g] = path_edge(path_e'(g), pol_i, rise_w, fall_w);
        assign cap_w[g]  = en_i & ctl_q.armed & edge_w[g];

        pwm_cap_chan #(
            .CNT_W(CNT_W)
        ) chan_i (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .cap_i (cap_w[g]),
            .clr_i (clr_w[g]),
            .cnt_i (ctl_q.cnt),
            .val_o (val_w[g]),
            .flag_o(flag_w[g]),
            .ovr_o (ovr_w[g])
        );
    end

    logic trig;
    logic saturated;
    assign trig      = edge_w[int'(PATH_PER)];
    assign saturated = ctl_q.tmo | (ctl_q.cnt == CNT_MAX);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        if (!en_i) begin
            ctl_d.cnt   = '0;
            ctl_d.armed = 1'b0;
            ctl_d.win   = 1'b0;
            ctl_d.tmo   = 1'b0;
        end else if (trig) begin
            ctl_d.cnt   = CNT_ONE;
            ctl_d.armed = 1'b1;
            ctl_d.win   = 1'b0;
            ctl_d.tmo   = 1'b0;
            ctl_d.valid = ctl_q.armed & ctl_q.win & ~saturated;
        end else begin
            if (ctl_q.cnt != CNT_MAX) begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ctl_d.tmo = saturated;
            if (cap_w[int'(PATH_WID)]) begin
                ctl_d.win = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign per_val_o  = val_w[int'(PATH_PER)];
    assign per_flag_o = flag_w[int'(PATH_PER)];
    assign per_ovr_o  = ovr_w[int'(PATH_PER)];
    assign wid_val_o  = val_w[int'(PATH_WID)];
    assign wid_flag_o = flag_w[int'(PATH_WID)];
    assign wid_ovr_o  = ovr_w[int'(PATH_WID)];
    assign valid_o    = ctl_q.valid;
    assign timeout_o  = ctl_q.tmo;

    // R3: an enabled trigger restarts counting at one
    assert_trig_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && trig) |=> (ctl_q.cnt == CNT_ONE));

    // R4: the arming trigger leaves the period register alone
    assert_first_trig_no_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && trig && !ctl_q.armed) |=> $stable(per_val_o));

    // R7: a valid strobe always comes with a set period flag
    assert_valid_has_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> per_flag_o);

    // R8: timeout is only reported while the counter is pinned
    assert_sat_timeout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |-> (ctl_q.cnt == CNT_MAX));

    // R9: disabling parks the counter and clears timeout
    assert_disable_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (ctl_q.cnt == '0 && !timeout_o));

endmodule

// File: tb/pwm_in_meter_tb.sv
module pwm_in_meter_tb_top;
    localparam int CNT_W = 10;
    localparam int MAXV  = (1 << CNT_W) - 1;
    localparam int FLEN  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw = 1'b0, pol = 1'b0, en = 1'b0, clr_per = 1'b0, clr_wid = 1'b0;
    logic [CNT_W-1:0] per_val, wid_val;
    logic per_flag, per_ovr, wid_flag, wid_ovr, valid, tmo;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int valid_seen = 0;

    always #2.5 clk = ~clk;

    pwm_in_meter #(.CNT_W(CNT_W), .SYNC_STAGES(2), .FILT_LEN(FLEN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .pol_i(pol), .en_i(en),
        .clr_per_i(clr_per), .clr_wid_i(clr_wid),
        .per_val_o(per_val), .per_flag_o(per_flag), .per_ovr_o(per_ovr),
        .wid_val_o(wid_val), .wid_flag_o(wid_flag), .wid_ovr_o(wid_ovr),
        .valid_o(valid), .timeout_o(tmo));

    // behavioural reference state
    int m_s0, m_s1, m_lvl, m_run, m_rise, m_fall, m_cnt, m_arm, m_win, m_tmo;
    int m_per, m_pf, m_po, m_wid, m_wf, m_wo, m_val;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s0 = 0; m_s1 = 0; m_lvl = 0; m_run = 0; m_rise = 0; m_fall = 0;
            m_cnt = 0; m_arm = 0; m_win = 0; m_tmo = 0;
            m_per = 0; m_pf = 0; m_po = 0; m_wid = 0; m_wf = 0; m_wo = 0; m_val = 0;
        end else begin
            int trg, oth, pc, wc, nl, nr, sat;
            trg = pol ? m_fall : m_rise;
            oth = pol ? m_rise : m_fall;
            pc = (en && m_arm && trg) ? 1 : 0;
            wc = (en && m_arm && oth) ? 1 : 0;
            // capture paths
            if (pc) begin
                m_per = m_cnt;
                m_po = (!clr_per && (m_po || m_pf)) ? 1 : 0;
                m_pf = 1;
            end else if (clr_per) begin m_pf = 0; m_po = 0; end
            if (wc) begin
                m_wid = m_cnt;
                m_wo = (!clr_wid && (m_wo || m_wf)) ? 1 : 0;
                m_wf = 1;
            end else if (clr_wid) begin m_wf = 0; m_wo = 0; end
            // control
            sat = (m_tmo || m_cnt == MAXV) ? 1 : 0;
            m_val = 0;
            if (!en) begin
                m_cnt = 0; m_arm = 0; m_win = 0; m_tmo = 0;
            end else if (trg) begin
                m_val = (m_arm && m_win && !sat) ? 1 : 0;
                m_cnt = 1; m_arm = 1; m_win = 0; m_tmo = 0;
            end else begin
                if (m_cnt != MAXV) m_cnt = m_cnt + 1;
                m_tmo = sat;
                if (wc) m_win = 1;
            end
            // filter
            nl = m_lvl; nr = 0;
            if (m_s1 != m_lvl) begin
                if (m_run == FLEN - 1) nl = m_s1;
                else nr = m_run + 1;
            end
            m_rise = (nl == 1 && m_lvl == 0) ? 1 : 0;
            m_fall = (nl == 0 && m_lvl == 1) ? 1 : 0;
            m_lvl = nl; m_run = nr;
            m_s1 = m_s0; m_s0 = raw;
        end
    end

    // compare against the reference every clock
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R3 per_val", per_val, m_per);
            chk("R2 wid_val", wid_val, m_wid);
            chk("R5 per_flag", per_flag, m_pf);
            chk("R5 wid_flag", wid_flag, m_wf);
            chk("R6 per_ovr", per_ovr, m_po);
            chk("R6 wid_ovr", wid_ovr, m_wo);
            chk("R7 valid", valid, m_val);
            chk("R8 timeout", tmo, m_tmo);
            if (valid) valid_seen++;
        end
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pwm(int h, int l, int n);
        for (int i = 0; i < n; i++) begin
            raw = 1'b1; wait_n(h);
            raw = 1'b0; wait_n(l);
        end
    endtask

    int held;

    initial begin
        wait_n(3);
        // R10 reset state
        chk("R10 per_val", per_val, 0); chk("R10 wid_val", wid_val, 0);
        chk("R10 flags", {per_flag, per_ovr, wid_flag, wid_ovr}, 0);
        chk("R10 valid/timeout", {valid, tmo}, 0);
        rst_n = 1'b1;
        wait_n(2);
        en = 1'b1;
        wait_n(2);
        // R4: one trigger only arms
        raw = 1'b1; wait_n(12);
        chk("R4 no period after first trigger", per_flag, 0);
        raw = 1'b0; wait_n(14);
        // R3 / R2 high time with rising trigger
        valid_seen = 0;
        pwm(7, 13, 4);
        wait_n(10);
        chk("R3 period 20", per_val, 20);
        chk("R2 high time 7", wid_val, 7);
        chk("R6 period overcapture", per_ovr, 1);
        chk("R7 valid strobes seen", (valid_seen >= 3) ? 1 : 0, 1);
        // R5 clear without capture
        clr_per = 1'b1; clr_wid = 1'b1; wait_n(1);
        clr_per = 1'b0; clr_wid = 1'b0;
        chk("R5 period flag cleared", per_flag, 0);
        chk("R5 width ovr cleared", wid_ovr, 0);
        // R5 clear held during captures
        clr_per = 1'b1;
        pwm(6, 6, 3);
        wait_n(10);
        chk("R5 clear beats ovr", per_ovr, 0);
        chk("R3 period 12", per_val, 12);
        clr_per = 1'b0;
        // R1 glitch shorter than the filter
        held = per_val;
        raw = 1'b1; wait_n(3); raw = 1'b0; wait_n(20);
        chk("R1 glitch ignored", per_val, held);
        // R1 exactly filter length accepted -> new capture
        raw = 1'b1; wait_n(4); raw = 1'b0; wait_n(20);
        chk("R1 four-clock pulse width", wid_val, 4);
        // R8 saturation
        wait_n(1100);
        chk("R8 timeout raised", tmo, 1);
        raw = 1'b1; wait_n(10);
        chk("R8 saturated period", per_val, MAXV);
        chk("R8 timeout cleared by trigger", tmo, 0);
        raw = 1'b0; wait_n(10);
        pwm(7, 13, 3);
        wait_n(8);
        chk("R3 period after recovery", per_val, 20);
        // R9 disabled
        en = 1'b0; wait_n(2);
        held = per_val;
        pwm(5, 5, 3);
        wait_n(10);
        chk("R9 period held while off", per_val, held);
        chk("R9 timeout low while off", tmo, 0);
        // R2 falling trigger: low time
        pol = 1'b1; wait_n(2);
        en = 1'b1;
        pwm(5, 11, 5);
        wait_n(10);
        chk("R2 period 16 falling trigger", per_val, 16);
        chk("R2 low time 11", wid_val, 11);
        wait_n(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule